// File: doc/BRIEF.md
# Bit-Test Conditional Skip Unit

This unit executes the two bit-test-and-skip instructions of a small 8-bit controller core. An instruction cycle has four clock phases. In the first phase the unit takes a 16-bit instruction word and the word that has already been prefetched after it. It decodes the bit index, the bank flag and the 8-bit file address, and forms a 12-bit data-memory address from one of three addressing schemes. In the second phase it reads that byte through a synchronous memory port. In the third phase it tests the chosen bit. In the fourth phase it decides whether to skip.

At the end of the test cycle the unit sends a one-clock result strobe to the fetch stage. The strobe carries a skip flag and the number of program words to advance. When the skip is taken, the unit marks the following one or two instruction cycles as squashed NOP cycles, so the prefetched instruction is never executed. A prefetched two-word instruction costs a second squashed cycle. Status flags are never touched. The ALU, the other instructions, interrupts and program memory lie outside the block.

Top module: `bit_skip_unit`

## Requirements
- R1: The instruction word has these fields: [15:12] opcode, [11:9] bit index, [8] bank flag, [7:0] file address. Opcode 4'b1011 is skip-when-clear and 4'b1010 is skip-when-set. Any other opcode is ignored: it causes no memory read and no result strobe.
- R2: Skip-when-clear skips when the tested bit of the addressed byte is 0. Skip-when-set skips when that bit is 1.
- R3: With the bank flag at 1, the address is {bsr_i, file address}.
- R4: With the bank flag at 0 and indexing not in force, file addresses 00h–5Fh map to 000h–05Fh and file addresses 60h–FFh map to F60h–FFFh.
- R5: With the bank flag at 0, ext_mode_i at 1 and a file address of at most 5Fh, the address is fsr2_i plus the file address, modulo 4096. ext_mode_i has no effect when the bank flag is 1 or when the file address is 60h or above.
- R6: phase_o counts 0,1,2,3 repeatedly from reset. An instruction is taken only when instr_valid_i is high during phase 0. mem_re_o is high for exactly the phase-1 clock of a taken instruction, with mem_addr_o holding the address. Read data is expected one clock later.
- R7: done_o is high for exactly one clock, in phase 0 right after the test cycle. skip_o is valid with it.
- R8: pc_inc_o with done_o is 1 with no skip, 2 when skipping a one-word instruction, and 3 when skipping a two-word instruction.
- R9: After a skip, nop_o is high for 4 clocks (one-word follower) or 8 clocks (two-word follower), starting with the done_o clock. Without a skip, nop_o stays low.
- R10: The prefetched word counts as two words when its bits [15:12] are 4'b1100 or its bits [15:10] are 6'b111011.
- R11: While nop_o is high, instr_valid_i is ignored: there is no read and no new strobe.
- R12: During reset, phase_o is 0, and done_o, skip_o, nop_o, mem_re_o and pc_inc_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction word present (sampled in phase 0) |
| instr_i | input | 16 | Instruction word |
| next_instr_i | input | 16 | Prefetched following word |
| bsr_i | input | 4 | Bank select register |
| ext_mode_i | input | 1 | Indexed mode enable |
| fsr2_i | input | 12 | Index base pointer |
| mem_rdata_i | input | 8 | Data memory read data (one clock after read) |
| mem_re_o | output | 1 | Data memory read strobe |
| mem_addr_o | output | 12 | Data memory address |
| phase_o | output | 2 | Current phase, 0..3 = Q1..Q4 |
| done_o | output | 1 | Result strobe to fetch stage |
| skip_o | output | 1 | Skip taken, valid with done_o |
| pc_inc_o | output | 2 | Program-word advance, valid with done_o |
| nop_o | output | 1 | Squashed instruction cycle in progress |

## Verification
The bench sweeps every bit index with both opcodes. A swapped test polarity or an off-by-one in bit selection therefore shows up as a wrong skip_o on half the cases. Addressing is probed at the boundaries 5Fh/60h, 00h and FFh, together with an index base near the top of memory. A design with the wrong window edge or a missing wrap drives a wrong mem_addr_o. Followers of one word and of two words, including a near-miss encoding, separate pc_inc_o values of 2 and 3 and squash windows of 4 and 8 clocks. A held instr_valid_i during the squash catches a unit that starts a new read while it should be idle.

// File: rtl/bts_pkg.sv
package bts_pkg;
  localparam int unsigned INSTR_W = 16;
  localparam int unsigned FILE_W  = 8;
  localparam int unsigned BANK_W  = 4;
  localparam int unsigned ADDR_W  = BANK_W + FILE_W;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned BIDX_W  = $clog2(DATA_W);

  localparam logic [3:0] OPC_SKIP_CLR = 4'b1011;
  localparam logic [3:0] OPC_SKIP_SET = 4'b1010;
  localparam logic [FILE_W-1:0] IDX_MAX = 8'h5F;

  localparam logic [1:0] PH_Q1 = 2'd0;
  localparam logic [1:0] PH_Q2 = 2'd1;
  localparam logic [1:0] PH_Q3 = 2'd2;
  localparam logic [1:0] PH_Q4 = 2'd3;

  typedef struct packed {
    logic [3:0]        opc;
    logic [BIDX_W-1:0] bidx;
    logic              bank;
    logic [FILE_W-1:0] faddr;
  } bts_word_t;

  function automatic logic is_dual_word(input logic [INSTR_W-1:0] w);
    return (w[15:12] == 4'b1100) || (w[15:10] == 6'b111011);
  endfunction
endpackage

// File: rtl/bts_decode.sv
module bts_decode
  import bts_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [INSTR_W-1:0] next_instr_i,
  output logic               is_bts_o,
  output logic               set_mode_o,
  output logic [BIDX_W-1:0]  bidx_o,
  output logic               bank_o,
  output logic [FILE_W-1:0]  faddr_o,
  output logic               dual_o
);
  bts_word_t w;
  assign w          = bts_word_t'(instr_i);
  assign is_bts_o   = (w.opc == OPC_SKIP_CLR) || (w.opc == OPC_SKIP_SET);
  assign set_mode_o = (w.opc == OPC_SKIP_SET);
  assign bidx_o     = w.bidx;
  assign bank_o     = w.bank;
  assign faddr_o    = w.faddr;
  assign dual_o     = is_dual_word(next_instr_i);
endmodule

// File: rtl/bts_addr_gen.sv
module bts_addr_gen
  import bts_pkg::*;
(
  input  logic              bank_i,
  input  logic [FILE_W-1:0] faddr_i,
  input  logic [BANK_W-1:0] bsr_i,
  input  logic              ext_mode_i,
  input  logic [ADDR_W-1:0] fsr2_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned HI_W = ADDR_W - FILE_W;

  logic low_win;
  assign low_win = (faddr_i <= IDX_MAX);

  always_comb begin
    if (bank_i)
      addr_o = {bsr_i, faddr_i};
    else if (ext_mode_i && low_win)
      addr_o = fsr2_i + {{HI_W{1'b0}}, faddr_i};
    else if (low_win)
      addr_o = {{HI_W{1'b0}}, faddr_i};
    else
      addr_o = {{HI_W{1'b1}}, faddr_i};
  end
endmodule

// File: rtl/bts_seq.sv
module bts_seq
  import bts_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              set_mode_i,
  input  logic [BIDX_W-1:0] bidx_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              dual_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_re_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        phase_o,
  output logic              done_o,
  output logic              skip_o,
  output logic [1:0]        pc_inc_o,
  output logic              nop_o
);
  logic [1:0]        phase_q;
  logic              active_q, mode_q, dual_q, hit_q;
  logic [BIDX_W-1:0] bidx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        nop_cnt_q, pc_inc_q;
  logic              done_q, skip_q;
  logic              accept, tbit;

  assign accept = req_i && (phase_q == PH_Q1) && !active_q && (nop_cnt_q == 2'd0);
  assign tbit   = mem_rdata_i[bidx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_Q1;
      active_q  <= 1'b0;
      mode_q    <= 1'b0;
      dual_q    <= 1'b0;
      hit_q     <= 1'b0;
      bidx_q    <= '0;
      addr_q    <= '0;
      nop_cnt_q <= 2'd0;
      pc_inc_q  <= 2'd0;
      done_q    <= 1'b0;
      skip_q    <= 1'b0;
    end else begin
      phase_q  <= phase_q + 2'd1;
      done_q   <= 1'b0;
      skip_q   <= 1'b0;
      pc_inc_q <= 2'd0;
      if (accept) begin
        active_q <= 1'b1;
        mode_q   <= set_mode_i;
        dual_q   <= dual_i;
        bidx_q   <= bidx_i;
        addr_q   <= addr_i;
      end
      if (active_q && phase_q == PH_Q3)
        hit_q <= mode_q ? tbit : ~tbit;
      if (active_q && phase_q == PH_Q4) begin
        active_q  <= 1'b0;
        done_q    <= 1'b1;
        skip_q    <= hit_q;
        pc_inc_q  <= hit_q ? (dual_q ? 2'd3 : 2'd2) : 2'd1;
        nop_cnt_q <= hit_q ? (dual_q ? 2'd2 : 2'd1) : 2'd0;
      end else if (phase_q == PH_Q4 && nop_cnt_q != 2'd0) begin
        nop_cnt_q <= nop_cnt_q - 2'd1;
      end
    end
  end

  assign mem_re_o   = active_q && (phase_q == PH_Q2);
  assign mem_addr_o = addr_q;
  assign phase_o    = phase_q;
  assign done_o     = done_q;
  assign skip_o     = skip_q;
  assign pc_inc_o   = pc_inc_q;
  assign nop_o      = (nop_cnt_q != 2'd0);
endmodule

// File: rtl/bit_skip_unit.sv
module bit_skip_unit
  import bts_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_valid_i,
  input  logic [15:0]       instr_i,
  input  logic [15:0]       next_instr_i,
  input  logic [3:0]        bsr_i,
  input  logic              ext_mode_i,
  input  logic [11:0]       fsr2_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              mem_re_o,
  output logic [11:0]       mem_addr_o,
  output logic [1:0]        phase_o,
  output logic              done_o,
  output logic              skip_o,
  output logic [1:0]        pc_inc_o,
  output logic              nop_o
);
  logic              is_bts, set_mode, bank, dual;
  logic [BIDX_W-1:0] bidx;
  logic [FILE_W-1:0] faddr;
  logic [ADDR_W-1:0] ea;

  bts_decode u_dec (
    .instr_i     (instr_i),
    .next_instr_i(next_instr_i),
    .is_bts_o    (is_bts),
    .set_mode_o  (set_mode),
    .bidx_o      (bidx),
    .bank_o      (bank),
    .faddr_o     (faddr),
    .dual_o      (dual)
  );

  bts_addr_gen u_agen (
    .bank_i    (bank),
    .faddr_i   (faddr),
    .bsr_i     (bsr_i),
    .ext_mode_i(ext_mode_i),
    .fsr2_i    (fsr2_i),
    .addr_o    (ea)
  );

  bts_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (instr_valid_i && is_bts),
    .set_mode_i (set_mode),
    .bidx_i     (bidx),
    .addr_i     (ea),
    .dual_i     (dual),
    .mem_rdata_i(mem_rdata_i),
    .mem_re_o   (mem_re_o),
    .mem_addr_o (mem_addr_o),
    .phase_o    (phase_o),
    .done_o     (done_o),
    .skip_o     (skip_o),
    .pc_inc_o   (pc_inc_o),
    .nop_o      (nop_o)
  );
endmodule

// File: rtl/bts_checker.sv
module bts_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mem_re_o,
  input logic [1:0] phase_o,
  input logic       done_o,
  input logic       skip_o,
  input logic [1:0] pc_inc_o,
  input logic       nop_o
);
  a_r6_read_in_q2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |-> phase_o == 2'd1);
  a_r6_phase_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> phase_o == $past(phase_o) + 2'd1);
  a_r7_done_in_q1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> phase_o == 2'd0);
  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_skip_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> done_o);
  a_r8_inc_plain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !skip_o) |-> pc_inc_o == 2'd1);
  a_r8_inc_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && skip_o) |-> pc_inc_o >= 2'd2);
  a_r9_nop_on_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && skip_o) |-> nop_o);
  a_r9_no_nop_plain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !skip_o) |-> !nop_o);
  a_r11_quiet_in_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nop_o |-> !mem_re_o);
endmodule

bind bit_skip_unit bts_checker u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mem_re_o(mem_re_o),
  .phase_o (phase_o),
  .done_o  (done_o),
  .skip_o  (skip_o),
  .pc_inc_o(pc_inc_o),
  .nop_o   (nop_o)
);

// File: tb/bit_skip_unit_tb.sv
`timescale 1ns/1ps
module bit_skip_unit_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        instr_valid = 1'b0, ext_mode = 1'b0;
  logic [15:0] instr = '0, next_instr = '0;
  logic [3:0]  bsr = '0;
  logic [11:0] fsr2 = '0;
  logic [7:0]  mem_rdata = '0;
  logic        mem_re, done, skip, nop;
  logic [11:0] mem_addr;
  logic [1:0]  phase, pc_inc;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  bit_skip_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(instr_valid), .instr_i(instr),
    .next_instr_i(next_instr), .bsr_i(bsr), .ext_mode_i(ext_mode), .fsr2_i(fsr2),
    .mem_rdata_i(mem_rdata), .mem_re_o(mem_re), .mem_addr_o(mem_addr),
    .phase_o(phase), .done_o(done), .skip_o(skip), .pc_inc_o(pc_inc), .nop_o(nop)
  );

  function automatic logic [7:0] memf(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
  endfunction

  always_ff @(posedge clk) if (mem_re) mem_rdata <= memf(mem_addr);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic align_q1();
    @(negedge clk);
    while (phase != 2'd0) @(negedge clk);
  endtask

  // one instruction; poke holds instr_valid through the squash window
  task automatic run_instr(input logic [3:0] opc, input int b, input logic a,
                           input logic [7:0] f, input logic [15:0] nxt,
                           input logic [3:0] bs, input logic ext,
                           input logic [11:0] base, input string atag, input bit poke);
    logic [11:0] ea;
    logic bitv, hit, two;
    int exp_inc, exp_nop, n, stray;
    if (a) ea = {bs, f};
    else if (ext && f <= 8'h5F) ea = base + {4'h0, f};
    else if (f <= 8'h5F) ea = {4'h0, f};
    else ea = {4'hF, f};
    bitv = memf(ea)[b];
    hit  = (opc == 4'b1011) ? !bitv : bitv;
    two  = (nxt[15:12] == 4'hC) || (nxt[15:10] == 6'b111011);
    exp_inc = hit ? (two ? 3 : 2) : 1;
    exp_nop = hit ? (two ? 8 : 4) : 0;
    align_q1();
    instr = {opc, b[2:0], a, f}; next_instr = nxt;
    bsr = bs; ext_mode = ext; fsr2 = base; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    chk(mem_re == 1'b1, "R6 read strobe in Q2", int'(mem_re), 1);
    chk(mem_addr == ea, atag, int'(mem_addr), int'(ea));
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R7 done strobe", int'(done), 1);
    chk(skip == hit, "R2 skip decision", int'(skip), int'(hit));
    chk(int'(pc_inc) == exp_inc, two ? "R10 R8 pc advance" : "R8 pc advance",
        int'(pc_inc), exp_inc);
    if (poke) instr_valid = 1'b1;
    n = 0; stray = 0;
    while (nop && n < 20) begin
      n++;
      @(negedge clk);
      if (mem_re || (done && nop)) stray++;
    end
    instr_valid = 1'b0;
    chk(n == exp_nop, "R9 squash length", n, exp_nop);
    if (poke) chk(stray == 0, "R11 input ignored in squash", stray, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(phase == 2'd0 && !done && !skip && !nop && !mem_re && pc_inc == 2'd0,
        "R12 reset state", {phase, done, skip, nop, mem_re, pc_inc}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_bit_sweep();
    for (int b = 0; b < 8; b++) begin
      run_instr(4'b1011, b, 1'b1, 8'h20 + 8'(b), 16'h0000, 4'h3, 1'b0, 12'h0, "R3 banked addr", 0);
      run_instr(4'b1010, b, 1'b1, 8'h20 + 8'(b), 16'h0000, 4'h3, 1'b0, 12'h0, "R3 banked addr", 0);
    end
  endtask

  task automatic t_access();
    run_instr(4'b1010, 2, 1'b0, 8'h5F, 16'h0000, 4'h7, 1'b0, 12'h0, "R4 access low edge", 0);
    run_instr(4'b1011, 5, 1'b0, 8'h60, 16'h0000, 4'h7, 1'b0, 12'h0, "R4 access high edge", 0);
    run_instr(4'b1010, 0, 1'b0, 8'h00, 16'h0000, 4'h7, 1'b0, 12'h0, "R4 access zero", 0);
    run_instr(4'b1011, 7, 1'b0, 8'hFF, 16'h0000, 4'h7, 1'b0, 12'h0, "R4 access top", 0);
  endtask

  task automatic t_indexed();
    run_instr(4'b1010, 3, 1'b0, 8'h5F, 16'h0000, 4'h2, 1'b1, 12'hFF0, "R5 indexed wrap", 0);
    run_instr(4'b1011, 1, 1'b0, 8'h10, 16'h0000, 4'h2, 1'b1, 12'h345, "R5 indexed", 0);
    run_instr(4'b1010, 4, 1'b0, 8'h60, 16'h0000, 4'h2, 1'b1, 12'h345, "R5 above window", 0);
    run_instr(4'b1011, 6, 1'b1, 8'h10, 16'h0000, 4'h9, 1'b1, 12'h345, "R5 banked unaffected", 0);
  endtask

  task automatic t_two_word();
    run_instr(4'b1011, 1, 1'b1, 8'h44, 16'hC123, 4'h1, 1'b0, 12'h0, "R3 addr", 0);
    run_instr(4'b1010, 1, 1'b1, 8'h44, 16'hC123, 4'h1, 1'b0, 12'h0, "R3 addr", 0);
    run_instr(4'b1011, 2, 1'b1, 8'h45, 16'hEC00, 4'h1, 1'b0, 12'h0, "R3 addr", 0);
    run_instr(4'b1010, 2, 1'b1, 8'h45, 16'hEC00, 4'h1, 1'b0, 12'h0, "R3 addr", 0);
    run_instr(4'b1011, 2, 1'b1, 8'h45, 16'hEB00, 4'h1, 1'b0, 12'h0, "R3 addr", 0);
    run_instr(4'b1010, 2, 1'b1, 8'h45, 16'hEB00, 4'h1, 1'b0, 12'h0, "R3 addr", 0);
  endtask

  task automatic t_ignore();
    int seen;
    align_q1();
    instr = 16'h9A42; instr_valid = 1'b1; seen = 0;
    @(negedge clk);
    instr_valid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (mem_re || done) seen++;
      @(negedge clk);
    end
    chk(seen == 0, "R1 foreign opcode ignored", seen, 0);
    // hold valid through a two-word squash for both polarities
    run_instr(4'b1011, 0, 1'b1, 8'h50, 16'hC000, 4'h5, 1'b0, 12'h0, "R3 addr", 1);
    run_instr(4'b1010, 0, 1'b1, 8'h50, 16'hC000, 4'h5, 1'b0, 12'h0, "R3 addr", 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_bit_sweep();
    t_access();
    t_indexed();
    t_two_word();
    t_ignore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule